// File: doc/BRIEF.md
# I2C Page-Write Memory Slave

This block is the serial front end of a small byte-addressable memory that behaves like a nonvolatile part. The memory is an on-chip array of 256 bytes. The block watches the two bus wires, SCL and SDA, after resynchronising them to the system clock. It recognises START and STOP. It shifts bytes in and out and acknowledges by pulling SDA low through an open-drain enable. It also keeps the address pointer. A master writes by sending the device byte and a byte address, followed by data bytes. The data bytes collect in a one-page staging buffer of 16 bytes, and the low four address bits wrap inside that page. STOP commits the buffer through a timed programming cycle. While that cycle runs the block refuses to acknowledge its device byte, so the master can poll until the cycle is done.

Reads come in two forms. A random read sets the pointer with a dummy write header, then issues a repeated START and a read header. A current-address read uses the pointer as it stands. The pointer advances after every byte read and wraps across the whole array. When the master answers a byte with no acknowledge, the block lets go of the bus and waits for the next START.

The controller is a single state machine with these states:
- S_IDLE: not addressed.
- S_DEV, S_ADR, S_WR: shifting in the device, address and data bytes.
- S_DEV_ACK, S_ADR_ACK, S_WR_ACK: driving the acknowledge bit.
- S_RD: shifting out a data byte.
- S_RD_WAIT: sampling the master's acknowledge.
- S_RD_NEXT: acknowledged, waiting for the clock to fall before loading the next byte.

Transitions:
- START moves any state to S_DEV, and STOP moves any state to S_IDLE.
- From S_DEV, the ninth falling edge leads to S_DEV_ACK on a match while not busy, and otherwise to S_IDLE.
- From S_DEV_ACK, a read header leads to S_RD and a write header leads to S_ADR.
- S_ADR leads to S_ADR_ACK, then S_WR, and S_WR and S_WR_ACK alternate.
- S_RD leads to S_RD_WAIT. From there, an acknowledge leads to S_RD_NEXT and then back to S_RD, and a no-acknowledge leads to S_IDLE.

Top module: `i2cpw_top`

## Requirements
- R1: A device byte is acknowledged (SDA pulled low in the ninth clock) only when its bits 7..4 equal 1010. Bits 3..1 are ignored, and bit 0 is the direction (1 = read, 0 = write).
- R2: In a write, the device byte, the byte address and every data byte are each acknowledged.
- R3: Each data byte goes to the pointer's location, and then only the low four pointer bits advance. They wrap from 15 to 0, while bits 7..4 stay fixed. For example, 12 bytes from 0x3A land in 0x3A..0x3F and 0x30..0x35, and 0x36..0x39 are left unchanged.
- R4: Loaded data becomes readable only after STOP and the programming cycle that follows. A STOP with no data byte loaded only sets the pointer and starts no cycle.
- R5: For WR_CYCLES system clocks after the STOP that commits a write, the device byte is not acknowledged. After that it is acknowledged again.
- R6: A random read returns the byte at the address sent in the dummy write header.
- R7: A current-address read returns the byte at the current pointer.
- R8: After each byte read, the pointer increments modulo 256. A sequential read continues at the next location, and reading 0xFF is followed by 0x00.
- R9: When more than 16 data bytes arrive in one write, the extra bytes keep wrapping in the page and replace earlier bytes. The last byte written to each location wins.
- R10: After the master answers a read byte with no acknowledge, SDA stays released across further clocks until the next START.
- R11: After reset, SDA is released, the pointer is 0, the array holds zeros and the device is not busy.
- R12: START and STOP are SDA edges while SCL is high. A START in the middle of a byte restarts device-byte reception.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock as seen on the wire |
| sda_i | input | 1 | Bus data as seen on the wire |
| sda_oe | output | 1 | When 1, SDA is pulled low |

## Verification
The bench sweeps every device-type nibble with two sets of the ignored bits. A decoder that checked the wrong bits would acknowledge a foreign code or reject its own.

Every page of the array is written starting at a different offset, and then all 256 bytes are read back in one sequential read. A pointer that carried into the page bits, or a sequential read that failed to advance, shows up as misplaced bytes. Single reads at 0xFF and then at 0x00 catch a pointer that saturates.

A write that loads 18 bytes checks that the overflow bytes overwrite earlier ones. Polling straight after STOP and again after the cycle catches a busy window that is missing or never ends. A read issued before STOP catches data that becomes visible too early. A pointer-only STOP followed by an immediate poll catches a cycle that starts with nothing to commit.

Clocking on after a no-acknowledge would expose a slave that keeps driving SDA. A START part-way through the address byte must restart cleanly with a read.

// File: rtl/i2cpw_pkg.sv
package i2cpw_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DEV,
        S_DEV_ACK,
        S_ADR,
        S_ADR_ACK,
        S_WR,
        S_WR_ACK,
        S_RD,
        S_RD_WAIT,
        S_RD_NEXT
    } ctl_state_t;

    localparam int BYTE_BITS = 8;

endpackage

// File: rtl/i2cpw_sync.sv
module i2cpw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= scl_i;
                    sda_pipe <= sda_i;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
                    sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/i2cpw_store.sv
module i2cpw_store #(
    parameter int ADDR_W    = 8,
    parameter int PAGE_W    = 4,
    parameter int WR_CYCLES = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              stop_det,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy
);

    localparam int DEPTH    = 1 << ADDR_W;
    localparam int PAGE_LEN = 1 << PAGE_W;
    localparam int UPPER_W  = ADDR_W - PAGE_W;
    localparam int CW       = $clog2(WR_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(WR_CYCLES - 1);

    logic [7:0]         mem   [DEPTH];
    logic [7:0]         stage [PAGE_LEN];
    logic [PAGE_LEN-1:0] mask;
    logic [UPPER_W-1:0] page_q;
    logic [CW-1:0]      cyc_q;
    logic               busy_q;
    logic               commit;

    assign commit  = busy_q && (cyc_q == LAST);
    assign busy    = busy_q;
    assign rd_data = mem[rd_addr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cyc_q  <= '0;
        end else if (busy_q) begin
            if (commit) begin
                busy_q <= 1'b0;
                cyc_q  <= '0;
            end else begin
                cyc_q <= cyc_q + 1'b1;
            end
        end else if (stop_det && (|mask)) begin
            busy_q <= 1'b1;
            cyc_q  <= '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask   <= '0;
            page_q <= '0;
            for (int i = 0; i < PAGE_LEN; i++) stage[i] <= 8'h00;
        end else if (commit) begin
            mask <= '0;
        end else if (wr_en) begin
            stage[wr_addr[PAGE_W-1:0]] <= wr_data;
            mask[wr_addr[PAGE_W-1:0]]  <= 1'b1;
            page_q                     <= wr_addr[ADDR_W-1:PAGE_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
        end else if (commit) begin
            for (int i = 0; i < PAGE_LEN; i++) begin
                if (mask[i]) mem[{page_q, PAGE_W'(i)}] <= stage[i];
            end
        end
    end

endmodule

// File: rtl/i2cpw_ctrl.sv
module i2cpw_ctrl
    import i2cpw_pkg::*;
#(
    parameter int         ADDR_W   = 8,
    parameter int         PAGE_W   = 4,
    parameter logic [3:0] DEV_CODE = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              busy_i,
    input  logic [7:0]        rd_data,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic [ADDR_W-1:0] ptr_o,
    output ctl_state_t        state_o
);

    localparam logic [3:0] FULL = 4'(BYTE_BITS);

    ctl_state_t        state, nxt;
    logic [7:0]        sh;
    logic [7:0]        tx;
    logic [3:0]        cnt;
    logic [ADDR_W-1:0] ptr;
    logic              byte_full;
    logic              addr_hit;
    logic              counting;
    logic              receiving;

    assign byte_full = (cnt == FULL);
    assign addr_hit  = (sh[7:4] == DEV_CODE) && !busy_i;
    assign counting  = (state == S_DEV) || (state == S_ADR) ||
                       (state == S_WR)  || (state == S_RD);
    assign receiving = (state == S_DEV) || (state == S_ADR) || (state == S_WR);

    always_comb begin
        nxt = state;
        if (start_det) begin
            nxt = S_DEV;
        end else if (stop_det) begin
            nxt = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE:    nxt = S_IDLE;
                S_DEV:     if (scl_fall && byte_full) nxt = addr_hit ? S_DEV_ACK : S_IDLE;
                S_DEV_ACK: if (scl_fall) nxt = sh[0] ? S_RD : S_ADR;
                S_ADR:     if (scl_fall && byte_full) nxt = S_ADR_ACK;
                S_ADR_ACK: if (scl_fall) nxt = S_WR;
                S_WR:      if (scl_fall && byte_full) nxt = S_WR_ACK;
                S_WR_ACK:  if (scl_fall) nxt = S_WR;
                S_RD:      if (scl_fall && byte_full) nxt = S_RD_WAIT;
                S_RD_WAIT: if (scl_rise) nxt = sda_s ? S_IDLE : S_RD_NEXT;
                S_RD_NEXT: if (scl_fall) nxt = S_RD;
                default:   nxt = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            sh  <= 8'h00;
            tx  <= 8'hFF;
            ptr <= '0;
        end else if (start_det || stop_det) begin
            cnt <= '0;
        end else begin
            if (scl_rise && counting) cnt <= cnt + 1'b1;
            if (scl_rise && receiving) sh <= {sh[6:0], sda_s};
            if (scl_fall) begin
                case (state)
                    S_DEV_ACK: if (sh[0]) tx <= rd_data;
                    S_ADR:     if (byte_full) begin
                                   cnt <= '0;
                                   ptr <= sh[ADDR_W-1:0];
                               end
                    S_WR:      if (byte_full) begin
                                   cnt <= '0;
                                   ptr <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + 1'b1};
                               end
                    S_RD:      if (byte_full) begin
                                   cnt <= '0;
                                   ptr <= ptr + 1'b1;
                               end else begin
                                   tx <= {tx[6:0], 1'b1};
                               end
                    S_RD_NEXT: tx <= rd_data;
                    S_DEV:     if (byte_full) cnt <= '0;
                    default:   ;
                endcase
            end
        end
    end

    always_comb begin
        sda_oe  = (state == S_DEV_ACK) || (state == S_ADR_ACK) || (state == S_WR_ACK) ||
                  ((state == S_RD) && !tx[7]);
        wr_en   = (state == S_WR) && scl_fall && byte_full && !start_det && !stop_det;
        wr_addr = ptr;
        wr_data = sh;
        ptr_o   = ptr;
        state_o = state;
    end

endmodule

// File: rtl/i2cpw_top.sv
module i2cpw_top
    import i2cpw_pkg::*;
#(
    parameter int         ADDR_W      = 8,
    parameter int         PAGE_W      = 4,
    parameter int         WR_CYCLES   = 1000,
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] DEV_CODE    = 4'b1010
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);

    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic              busy;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data;
    logic [7:0]        rd_data;
    logic [ADDR_W-1:0] ptr;
    ctl_state_t        state;

    i2cpw_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2cpw_ctrl #(
        .ADDR_W   (ADDR_W),
        .PAGE_W   (PAGE_W),
        .DEV_CODE (DEV_CODE)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .busy_i    (busy),
        .rd_data   (rd_data),
        .sda_oe    (sda_oe),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .ptr_o     (ptr),
        .state_o   (state)
    );

    i2cpw_store #(
        .ADDR_W    (ADDR_W),
        .PAGE_W    (PAGE_W),
        .WR_CYCLES (WR_CYCLES)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .stop_det (stop_det),
        .rd_addr  (ptr),
        .rd_data  (rd_data),
        .busy     (busy)
    );

endmodule

// File: rtl/i2cpw_checker.sv
module i2cpw_checker
    import i2cpw_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sda_oe,
    input logic              busy,
    input logic              wr_en,
    input logic              stop_det,
    input logic              start_det,
    input logic              scl_fall,
    input logic [ADDR_W-1:0] ptr,
    input ctl_state_t        state
);

    // R5: no address acknowledge while the programming cycle runs
    p_busy_no_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (state != S_DEV_ACK));

    // R4: a programming cycle is only ever started by a STOP
    p_busy_after_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_det));

    // R3: a buffered data byte never changes the page bits of the pointer
    p_page_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W])));

    // R8: finishing a read byte advances the pointer by one
    p_rd_advance_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == S_RD_WAIT) |-> (ptr == $past(ptr) + 1'b1));

    // R12: SDA drive only moves after an SCL fall or a bus condition
    p_sda_steady_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(scl_fall) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_oe));

endmodule

bind i2cpw_top i2cpw_checker #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_oe    (sda_oe),
    .busy      (busy),
    .wr_en     (wr_en),
    .stop_det  (stop_det),
    .start_det (start_det),
    .scl_fall  (scl_fall),
    .ptr       (ptr),
    .state     (state)
);

// File: tb/i2cpw_top_test.sv
`timescale 1ns/1ps
module i2cpw_top_test;

    localparam int WRC = 400;
    localparam int Q   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe;
    logic sda_line;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    logic [7:0] exp_mem [256];
    logic [7:0] mptr;

    assign sda_line = m_sda & ~sda_oe;

    always #4 clk = ~clk;

    i2cpw_top #(.WR_CYCLES(WRC)) uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (m_scl),
        .sda_i  (sda_line),
        .sda_oe (sda_oe)
    );

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wclk(Q);
        m_scl = 1'b1; wclk(Q);
        m_sda = 1'b0; wclk(Q);
        m_scl = 1'b0; wclk(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wclk(Q);
        m_scl = 1'b1; wclk(Q);
        m_sda = 1'b1; wclk(2 * Q);
    endtask

    task automatic bit_w(input logic b);
        m_sda = b;    wclk(Q);
        m_scl = 1'b1; wclk(2 * Q);
        m_scl = 1'b0; wclk(Q);
    endtask

    task automatic bit_r(output logic b);
        m_sda = 1'b1; wclk(Q);
        m_scl = 1'b1; wclk(Q);
        b = sda_line; wclk(Q);
        m_scl = 1'b0; wclk(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) bit_w(v[i]);
        bit_r(b);
        ack = ~b;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            bit_r(b);
            v[i] = b;
        end
        bit_w(~give_ack);
    endtask

    task automatic poll(output logic ack);
        bus_start();
        send_byte(8'hA0, ack);
        bus_stop();
    endtask

    function automatic logic [7:0] gen(input int seed, input int j);
        return 8'((seed * 37 + j * 11 + 5) & 8'hFF);
    endfunction

    task automatic wait_commit(input string tag);
        logic ack;
        poll(ack);
        chk({tag, " R5 poll during cycle"}, ack, 0);
        wclk(WRC + 20);
        poll(ack);
        chk({tag, " R5 poll after cycle"}, ack, 1);
    endtask

    task automatic write_seq(input logic [7:0] a, input int n, input int seed, input string tag);
        logic ack;
        logic [7:0] loc;
        bus_start();
        send_byte(8'hA0, ack);
        chk({tag, " R2 device ack"}, ack, 1);
        send_byte(a, ack);
        chk({tag, " R2 address ack"}, ack, 1);
        loc = a;
        for (int j = 0; j < n; j++) begin
            send_byte(gen(seed, j), ack);
            chk({tag, " R2 data ack"}, ack, 1);
            exp_mem[loc] = gen(seed, j);
            loc = {loc[7:4], loc[3:0] + 4'd1};
        end
        mptr = loc;
        bus_stop();
        wait_commit(tag);
    endtask

    task automatic rand_read(input logic [7:0] a, input int n, input string tag);
        logic ack;
        logic [7:0] v;
        bus_start();
        send_byte(8'hA0, ack);
        chk({tag, " R6 header ack"}, ack, 1);
        send_byte(a, ack);
        bus_start();
        send_byte(8'hA1, ack);
        chk({tag, " R6 read header ack"}, ack, 1);
        mptr = a;
        for (int j = 0; j < n; j++) begin
            recv_byte(j < n - 1, v);
            chk({tag, " R6 R8 data"}, v, exp_mem[mptr]);
            mptr = mptr + 8'd1;
        end
        bus_stop();
    endtask

    task automatic cur_read(input string tag);
        logic ack;
        logic [7:0] v;
        bus_start();
        send_byte(8'hA1, ack);
        chk({tag, " R7 header ack"}, ack, 1);
        recv_byte(1'b0, v);
        chk({tag, " R7 data"}, v, exp_mem[mptr]);
        mptr = mptr + 8'd1;
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic b;
        logic [7:0] v;
        int relcnt;
        for (int i = 0; i < 256; i++) exp_mem[i] = 8'h00;
        mptr = 8'h00;
        wclk(5);
        chk("R11 sda released in reset", sda_oe, 0);
        rst_n = 1'b1;
        wclk(5);
        chk("R11 sda released after reset", sda_oe, 0);
        poll(ack);
        chk("R11 not busy after reset", ack, 1);
        cur_read("R11 zero array at pointer 0");

        // R1: sweep the device-type nibble and the ignored bits
        for (int nib = 0; nib < 16; nib++) begin
            for (int k = 0; k < 8; k += 7) begin
                bus_start();
                send_byte({4'(nib), 3'(k), 1'b0}, ack);
                bus_stop();
                chk($sformatf("R1 code %0h sel %0d", nib, k), ack, (nib == 10) ? 1 : 0);
            end
        end

        // R3: fill every page starting at a different offset
        for (int p = 0; p < 16; p++) begin
            write_seq({4'(p), 4'((p * 5) % 16)}, 16, p, $sformatf("R3 page %0d", p));
        end
        rand_read(8'h00, 256, "R8 full sweep");
        cur_read("R8 wrap after sweep");

        // R3: 12 bytes from offset 10 of page 3 leave 0x36..0x39 as they were
        write_seq(8'h3A, 12, 40, "R3 twelve from 0x3A");
        rand_read(8'h30, 16, "R3 page 3 readback");

        // R9: 18 bytes into page 5
        write_seq(8'h50, 18, 77, "R9 overflow");
        rand_read(8'h50, 2, "R9 overwritten slots");
        rand_read(8'h52, 1, "R9 untouched slot");

        // R8: pointer wrap from 0xFF to 0x00
        rand_read(8'hFF, 1, "R8 read top");
        cur_read("R8 wrapped to 0");

        // R4: pointer-only STOP starts no cycle
        bus_start();
        send_byte(8'hA0, ack);
        send_byte(8'h20, ack);
        bus_stop();
        poll(ack);
        chk("R4 no cycle without data", ack, 1);
        mptr = 8'h20;
        cur_read("R4 pointer set by address only");

        // R4: loaded data invisible before STOP and cycle
        bus_start();
        send_byte(8'hA0, ack);
        send_byte(8'h70, ack);
        send_byte(8'h55, ack);
        chk("R4 data ack", ack, 1);
        bus_start();
        send_byte(8'hA0, ack);
        send_byte(8'h70, ack);
        bus_start();
        send_byte(8'hA1, ack);
        recv_byte(1'b0, v);
        chk("R4 old value before commit", v, exp_mem[8'h70]);
        bus_stop();
        wait_commit("R4 deferred");
        exp_mem[8'h70] = 8'h55;
        rand_read(8'h70, 1, "R4 new value after commit");

        // R10: after a NACKed read SDA stays released
        bus_start();
        send_byte(8'hA1, ack);
        recv_byte(1'b0, v);
        chk("R10 read data", v, exp_mem[mptr]);
        mptr = mptr + 8'd1;
        relcnt = 0;
        for (int i = 0; i < 9; i++) begin
            bit_r(b);
            if (b) relcnt++;
        end
        chk("R10 bus released after nack", relcnt, 9);
        bus_stop();

        // R12: START inside the address byte restarts device reception
        bus_start();
        send_byte(8'hA0, ack);
        bit_w(1'b1);
        bit_w(1'b0);
        bit_w(1'b1);
        bus_start();
        send_byte(8'hA1, ack);
        chk("R12 restart header ack", ack, 1);
        recv_byte(1'b0, v);
        chk("R12 data after restart", v, exp_mem[mptr]);
        mptr = mptr + 8'd1;
        bus_stop();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule